// File: doc/BRIEF.md
# GPIO Controller with Pin Interrupts

This block is a general-purpose pin controller for up to 32 pads, reached through a plain strobe-based register interface. Software selects which pads are driven, sets the driven values and reads back the pad levels. Pad levels pass through a synchroniser chain before anything inside the block uses them. The tri-state pad cell sits outside the block. The controller hands it three separate vectors: an output enable, a drive value, and the raw pad level coming in.

Any pin can be made an interrupt source. A per-pin two-bit mode picks the trigger: high level, low level, rising edge or falling edge. A trigger on an enabled pin sets that pin's bit in a sticky status register. The single interrupt line is high while any status bit is set. Reading the status register returns its contents and clears it in the same access. A trigger that arrives in the cycle of that read is not lost.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset every register is zero. Every pin is an input (pad_oe = 0), pad_out = 0, irq = 0 and rdata = 0.
- R2: The direction register sits at byte address 0x00 and is read/write. Bit n = 1 makes pin n an output, and pad_oe equals this register from the cycle after the write.
- R3: The output register sits at address 0x08 and is read/write. pad_out equals this register from the cycle after the write.
- R4: The input register sits at address 0x04 and is read-only. It returns pad_in after a two-stage synchroniser. A pad change made before clock edge k is returned by a read strobed at edge k+2 or later. A read strobed at edge k+1 still returns the old value.
- R5: The interrupt enable register sits at address 0x0C and is read/write. A pin whose enable bit is 0 never sets its status bit.
- R6: The mode registers sit at 0x10 (low mode bit) and 0x14 (high mode bit). The per-pin mode {0x14 bit, 0x10 bit} means: 00 triggers while the synchronised level is high, 01 while it is low, 10 on a rising edge, 11 on a falling edge.
- R7: An edge compares the synchronised level with its value one cycle earlier. A held level after an edge does not trigger again.
- R8: The status register sits at address 0x18 and is read-only. It is sticky: a set bit stays set until the register is read. A read returns the bits set before the read edge and clears them. irq is high exactly while any status bit is set.
- R9: If a trigger occurs in the same cycle as a status read, the status is cleared but that trigger's bit is set after the read.
- R10: For a level or rising-edge trigger, irq rises on the third clock edge after the pad change. It stays low after the first and second edges.
- R11: rdata updates on the edge where rd_stb is sampled high and holds its value while rd_stb is low. Addresses outside the map read as zero. Writes to 0x04, 0x18 or unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per write |
| rd_stb | input | 1 | Read strobe, one cycle per read |
| addr | input | 5 | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_oe | output | 32 | Pad output enable, 1 = driven |
| pad_out | output | 32 | Pad drive values |
| irq | output | 1 | Interrupt request, high while status is non-zero |

## Verification
Corrupted status state shows on irq and on the next status read. A lost sticky bit drops irq early, and a failed clear leaves irq high on the cycle after the read. A wrong synchroniser depth or a wrong edge reference moves the irq rise away from the third edge, or makes a held level trigger again; a per-cycle reference comparison catches this within one cycle. A write decoded to the wrong register shows on pad_oe or pad_out the next cycle, or on the following read of that register.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   localparam int unsigned MAP_ADDR_W = 5;

   localparam logic [MAP_ADDR_W-1:0] OFS_DIR  = 5'h00;
   localparam logic [MAP_ADDR_W-1:0] OFS_IN   = 5'h04;
   localparam logic [MAP_ADDR_W-1:0] OFS_OUT  = 5'h08;
   localparam logic [MAP_ADDR_W-1:0] OFS_IEN  = 5'h0C;
   localparam logic [MAP_ADDR_W-1:0] OFS_TYP0 = 5'h10;
   localparam logic [MAP_ADDR_W-1:0] OFS_TYP1 = 5'h14;
   localparam logic [MAP_ADDR_W-1:0] OFS_STAT = 5'h18;

   // per-pin trigger mode, {high mode bit, low mode bit}
   typedef enum logic [1:0] {
      TRIG_HIGH = 2'b00,
      TRIG_LOW  = 2'b01,
      TRIG_RISE = 2'b10,
      TRIG_FALL = 2'b11
   } trig_e;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("gpio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] chain_q [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) chain_q[k] <= '0;
      end else begin
         chain_q[0] <= din;
         for (int k = 1; k < STAGES; k++) chain_q[k] <= chain_q[k-1];
      end
   end

   assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   output logic [W-1:0]      dir_q,
   output logic [W-1:0]      out_q,
   output logic [W-1:0]      ien_q,
   output logic [W-1:0]      typ0_q,
   output logic [W-1:0]      typ1_q
);

   logic sel_dir, sel_out, sel_ien, sel_typ0, sel_typ1;

   always_comb begin
      sel_dir  = wr_stb && (addr == ADDR_W'(OFS_DIR));
      sel_out  = wr_stb && (addr == ADDR_W'(OFS_OUT));
      sel_ien  = wr_stb && (addr == ADDR_W'(OFS_IEN));
      sel_typ0 = wr_stb && (addr == ADDR_W'(OFS_TYP0));
      sel_typ1 = wr_stb && (addr == ADDR_W'(OFS_TYP1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         out_q  <= '0;
         ien_q  <= '0;
         typ0_q <= '0;
         typ1_q <= '0;
      end else begin
         if (sel_dir)  dir_q  <= wdata;
         if (sel_out)  out_q  <= wdata;
         if (sel_ien)  ien_q  <= wdata;
         if (sel_typ0) typ0_q <= wdata;
         if (sel_typ1) typ1_q <= wdata;
      end
   end

endmodule

// File: rtl/gpio_trigger.sv
module gpio_trigger
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] ien,
   input  logic [W-1:0] typ0,
   input  logic [W-1:0] typ1,
   output logic [W-1:0] hit
);

   logic [W-1:0] lvl_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_prev_q <= '0;
      else        lvl_prev_q <= lvl;
   end

   generate
      for (genvar i = 0; i < W; i++) begin : g_pin
         trig_e mode;
         logic  cond;
         assign mode = trig_e'({typ1[i], typ0[i]});
         always_comb begin
            case (mode)
               TRIG_HIGH: cond = lvl[i];
               TRIG_LOW:  cond = ~lvl[i];
               TRIG_RISE: cond = lvl[i] & ~lvl_prev_q[i];
               TRIG_FALL: cond = ~lvl[i] & lvl_prev_q[i];
               default:   cond = 1'b0;
            endcase
         end
         assign hit[i] = ien[i] & cond;
      end
   endgenerate

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
   import gpio_irq_pkg::*;
#(
   parameter int unsigned NUM_PINS    = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_stb,
   input  logic                rd_stb,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [NUM_PINS-1:0] wdata,
   output logic [NUM_PINS-1:0] rdata,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_out,
   output logic                irq
);

   localparam int unsigned W = NUM_PINS;

   generate
      if (NUM_PINS < 1 || NUM_PINS > 32) begin : g_bad_pins
         $error("gpio_irq_ctrl: NUM_PINS must be in 1..32");
      end
      if (ADDR_W < MAP_ADDR_W) begin : g_bad_addr
         $error("gpio_irq_ctrl: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [W-1:0] dir_q, out_q, ien_q, typ0_q, typ1_q;
   logic [W-1:0] lvl_sync;
   logic [W-1:0] trig_hit;
   logic [W-1:0] status_q;
   logic [W-1:0] rdata_q;
   logic [W-1:0] rd_mux;
   logic         stat_rd;

   gpio_regfile #(.W(W), .ADDR_W(ADDR_W)) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_stb (wr_stb),
      .addr   (addr),
      .wdata  (wdata),
      .dir_q  (dir_q),
      .out_q  (out_q),
      .ien_q  (ien_q),
      .typ0_q (typ0_q),
      .typ1_q (typ1_q)
   );

   gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (pad_in),
      .dout  (lvl_sync)
   );

   gpio_trigger #(.W(W)) u_trig (
      .clk   (clk),
      .rst_n (rst_n),
      .lvl   (lvl_sync),
      .ien   (ien_q),
      .typ0  (typ0_q),
      .typ1  (typ1_q),
      .hit   (trig_hit)
   );

   assign stat_rd = rd_stb && (addr == ADDR_W'(OFS_STAT));

   // sticky status: read clears, a same-cycle trigger survives the clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status_q <= '0;
      else if (stat_rd) status_q <= trig_hit;
      else              status_q <= status_q | trig_hit;
   end

   always_comb begin
      case (addr)
         ADDR_W'(OFS_DIR):  rd_mux = dir_q;
         ADDR_W'(OFS_IN):   rd_mux = lvl_sync;
         ADDR_W'(OFS_OUT):  rd_mux = out_q;
         ADDR_W'(OFS_IEN):  rd_mux = ien_q;
         ADDR_W'(OFS_TYP0): rd_mux = typ0_q;
         ADDR_W'(OFS_TYP1): rd_mux = typ1_q;
         ADDR_W'(OFS_STAT): rd_mux = status_q;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= rd_mux;
   end

   assign rdata   = rdata_q;
   assign pad_oe  = dir_q;
   assign pad_out = out_q;
   assign irq     = |status_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
   import gpio_irq_pkg::*;
#(
   parameter int unsigned W      = 32,
   parameter int unsigned ADDR_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              rd_stb,
   input logic [ADDR_W-1:0] addr,
   input logic [W-1:0]      wdata,
   input logic [W-1:0]      rdata,
   input logic [W-1:0]      pad_oe,
   input logic [W-1:0]      pad_out,
   input logic              irq,
   input logic [W-1:0]      status_q,
   input logic [W-1:0]      hit,
   input logic [W-1:0]      ien_q
);

   a_r1_oe_clear_at_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && !irq));

   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == ADDR_W'(OFS_DIR)) |=> (pad_oe == $past(wdata)));

   a_r3_out_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr == ADDR_W'(OFS_OUT)) |=> (pad_out == $past(wdata)));

   a_r5_no_disabled_set: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((status_q & ~$past(status_q) & ~$past(ien_q)) == '0));

   a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_stb && addr == ADDR_W'(OFS_STAT))
         |=> ((status_q & $past(status_q)) == $past(status_q)));

   a_r8_read_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr == ADDR_W'(OFS_STAT)) |=> (rdata == $past(status_q)));

   a_r9_clear_keeps_new: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && addr == ADDR_W'(OFS_STAT)) |=> (status_q == $past(hit)));

   a_r10_hit_raises_irq: assert property (@(posedge clk) disable iff (!rst_n)
      (|hit) |=> irq);

   a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_stb |=> $stable(rdata));

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.W(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_stb   (wr_stb),
   .rd_stb   (rd_stb),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .pad_oe   (pad_oe),
   .pad_out  (pad_out),
   .irq      (irq),
   .status_q (status_q),
   .hit      (trig_hit),
   .ien_q    (ien_q)
);

// File: tb/gpio_irq_ctrl_test.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0;
   logic        rd_stb = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [31:0] pad_in = '0;
   logic [31:0] pad_oe;
   logic [31:0] pad_out;
   logic        irq;

   int total = 0;
   int bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   gpio_irq_ctrl uut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .addr(addr), .wdata(wdata), .rdata(rdata), .pad_in(pad_in),
      .pad_oe(pad_oe), .pad_out(pad_out), .irq(irq)
   );

   // reference model state
   logic [31:0] m_dir, m_out, m_ien, m_t0, m_t1, m_st, m_s1, m_s2, m_prev, m_rd;

   function automatic logic [31:0] model_hit(logic [31:0] s, logic [31:0] p,
                                             logic [31:0] en, logic [31:0] t0,
                                             logic [31:0] t1);
      logic [31:0] h;
      for (int i = 0; i < 32; i++) begin
         case ({t1[i], t0[i]})
            2'b00:   h[i] = s[i];
            2'b01:   h[i] = ~s[i];
            2'b10:   h[i] = s[i] & ~p[i];
            default: h[i] = ~s[i] & p[i];
         endcase
      end
      return h & en;
   endfunction

   function automatic logic [31:0] model_read(logic [4:0] a);
      case (a)
         5'h00:   return m_dir;
         5'h04:   return m_s2;
         5'h08:   return m_out;
         5'h0C:   return m_ien;
         5'h10:   return m_t0;
         5'h14:   return m_t1;
         5'h18:   return m_st;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      chk("R2", "pad_oe", pad_oe, m_dir);
      chk("R3", "pad_out", pad_out, m_out);
      chk("R8", "irq", {31'h0, irq}, {31'h0, |m_st});
      chk("R11", "rdata", rdata, m_rd);
   endtask

   task automatic model_reset();
      m_dir = '0; m_out = '0; m_ien = '0; m_t0 = '0; m_t1 = '0;
      m_st = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_rd = '0;
   endtask

   // one clock: model advances with the inputs present before the edge
   task automatic tick();
      logic [31:0] h, nst, nrd;
      h   = model_hit(m_s2, m_prev, m_ien, m_t0, m_t1);
      nst = ((rd_stb && addr == 5'h18) ? 32'h0 : m_st) | h;
      nrd = rd_stb ? model_read(addr) : m_rd;
      @(posedge clk);
      if (wr_stb) begin
         case (addr)
            5'h00: m_dir = wdata;
            5'h08: m_out = wdata;
            5'h0C: m_ien = wdata;
            5'h10: m_t0  = wdata;
            5'h14: m_t1  = wdata;
            default: ;
         endcase
      end
      m_st = nst; m_rd = nrd;
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_write(logic [4:0] a, logic [31:0] d);
      wr_stb = 1'b1; addr = a; wdata = d;
      tick();
      wr_stb = 1'b0;
   endtask

   task automatic do_read(logic [4:0] a);
      rd_stb = 1'b1; addr = a;
      tick();
      rd_stb = 1'b0;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [4:0] amap [9];
      amap = '{5'h00, 5'h04, 5'h08, 5'h0C, 5'h10, 5'h14, 5'h18, 5'h1C, 5'h02};
      void'($urandom(32'd20240611));
      model_reset();
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "pad_oe", pad_oe, 32'h0);
      chk("R1", "pad_out", pad_out, 32'h0);
      chk("R1", "irq", {31'h0, irq}, 32'h0);
      chk("R1", "rdata", rdata, 32'h0);
      rst_n = 1'b1;
      tick();
      do_read(5'h0C);
      chk("R1", "ien after reset", rdata, 32'h0);

      // R2 / R3
      do_write(5'h00, 32'hA5A5_0F0F);
      chk("R2", "pad_oe after write", pad_oe, 32'hA5A5_0F0F);
      do_read(5'h00);
      chk("R2", "dir readback", rdata, 32'hA5A5_0F0F);
      do_write(5'h08, 32'h1234_5678);
      chk("R3", "pad_out after write", pad_out, 32'h1234_5678);

      // R11 writes to read-only / unmapped change nothing
      do_write(5'h04, 32'hFFFF_FFFF);
      do_write(5'h18, 32'hFFFF_FFFF);
      do_write(5'h1C, 32'hFFFF_FFFF);
      do_read(5'h04);
      chk("R11", "input reg after write", rdata, 32'h0);
      do_read(5'h18);
      chk("R11", "status after write", rdata, 32'h0);
      do_read(5'h1C);
      chk("R11", "unmapped read", rdata, 32'h0);
      chk("R11", "irq after ro writes", {31'h0, irq}, 32'h0);

      // R4 synchroniser latency on the input register
      pad_in = 32'h00F0_0000;
      tick();
      do_read(5'h04);
      chk("R4", "read one edge later", rdata, 32'h0);
      do_read(5'h04);
      chk("R4", "read two edges later", rdata, 32'h00F0_0000);
      pad_in = 32'h0;
      repeat (3) tick();

      // R6 modes: pin1 low level, pin2 falling, pin3 rising
      do_write(5'h10, 32'h0000_0006);
      do_write(5'h14, 32'h0000_000C);
      do_write(5'h0C, 32'h0000_0008);
      // R10 rising-edge latency
      pad_in[3] = 1'b1;
      tick(); chk("R10", "irq edge1", {31'h0, irq}, 32'h0);
      tick(); chk("R10", "irq edge2", {31'h0, irq}, 32'h0);
      tick(); chk("R10", "irq edge3", {31'h0, irq}, 32'h1);
      repeat (3) tick();
      do_read(5'h18);
      chk("R8", "status read value", rdata, 32'h0000_0008);
      tick();
      chk("R7", "held level no retrigger", {31'h0, irq}, 32'h0);

      // R5 disabled pin 4 toggles
      pad_in[4] = 1'b1; repeat (4) tick();
      pad_in[4] = 1'b0; repeat (4) tick();
      do_read(5'h18);
      chk("R5", "disabled pin status", rdata & 32'h10, 32'h0);

      // R6 falling edge on pin2
      do_write(5'h0C, 32'h0000_000C);
      pad_in[2] = 1'b1; repeat (4) tick();
      chk("R6", "no fall on rise", {31'h0, irq}, 32'h0);
      pad_in[2] = 1'b0; repeat (4) tick();
      do_read(5'h18);
      chk("R6", "fall sets bit2", rdata, 32'h0000_0004);

      // R9 low-level pin1 persists through the clearing read
      do_write(5'h0C, 32'h0000_0002);
      repeat (3) tick();
      chk("R6", "low level fires", {31'h0, irq}, 32'h1);
      do_read(5'h18);
      chk("R9", "read value", rdata, 32'h0000_0002);
      chk("R9", "irq kept after clear", {31'h0, irq}, 32'h1);
      pad_in[1] = 1'b1; repeat (3) tick();
      do_read(5'h18);
      tick();
      chk("R8", "irq cleared after read", {31'h0, irq}, 32'h0);

      // random phase
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = $urandom_range(0, 15);
         if ($urandom_range(0, 3) == 0)
            pad_in = pad_in ^ ($urandom() & $urandom() & $urandom());
         if (r < 2) begin
            wr_stb = 1'b1; addr = amap[$urandom_range(0, 8)]; wdata = $urandom();
         end else if (r < 6) begin
            rd_stb = 1'b1; addr = amap[$urandom_range(0, 8)];
         end else if (r == 6) begin
            wr_stb = 1'b1; rd_stb = 1'b1; addr = amap[$urandom_range(0, 8)];
            wdata = $urandom();
         end
         tick();
         wr_stb = 1'b0; rd_stb = 1'b0;
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule